// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

A synthesizable functional model of a word-organised static RAM with independent byte lanes. It serves as the target of a memory-controller testbench. All control inputs (chip enable, write enable, output enable and one strobe per byte lane, all active low) are sampled on a simulation clock. The bidirectional data bus is split into a data-in port, a registered data-out port and a per-lane drive-enable output. A bench can therefore see when the model would drive the bus, and flag contention with the controller.

The control combination selects one of four modes: deselected, output disabled, read and write. Each lane keeps its own write window: chip enable low, write enable low and that lane's strobe low. Address and data are held from the last sampled cycle in which the window is open. The array is updated on the edge at which the window is seen closed, so data is taken at whichever control ends the write. A read sampled on that same edge returns the new data. The default configuration is 1024 words by two 8-bit lanes. With an address width of 16 it gives the full 65,536 × 16 organisation.

Top module: `bytelane_sram`

## Requirements
- R1: While rst_ni is low and on the first edge after release, drv_o is all zero and dout_o is zero.
- R2: With ce_ni high at a sampling edge, drv_o is all zero and dout_o is zero after that edge, whatever we_ni, oe_ni and be_ni are. No array location is written.
- R3: With ce_ni low, we_ni high and oe_ni low at an edge, after that edge drv_o[l] equals the inverse of be_ni[l]. A driving lane shows its byte of the addressed word (lane 0 is bits 7:0 under be_ni[0], lane 1 is bits 15:8 under be_ni[1]). A lane that does not drive reads zero.
- R4: With ce_ni low, we_ni high and oe_ni high, drv_o is all zero and dout_o is zero after the edge.
- R5: With ce_ni and we_ni both low, drv_o is all zero after the edge regardless of oe_ni. Every lane whose strobe is low is written.
- R6: A lane whose strobe stays high for the whole write leaves its byte of the addressed word unchanged.
- R7: A lane's write takes address and data from the last sampled cycle in which ce_ni, we_ni and its strobe were all low. It is committed on the edge where any of the three is first seen high, so separate lanes may close on different edges.
- R8: A read sampled on the edge that commits a write to the same address returns the newly written data.
- R9: Depth is 2^ADDR_W words and the word has LANES lanes of LANE_W bits each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| be_ni | input | LANES | Byte-lane strobes, active low |
| din_i | input | LANES*LANE_W | Write data from the bus |
| dout_o | output | LANES*LANE_W | Read data, zero on undriven lanes |
| drv_o | output | LANES | Per-lane bus drive enable |

## Verification
The bench builds the model with ADDR_W set to 4 and the default two 8-bit lanes. Sixteen words let it sweep every address with full-word writes and with each single-lane write, and read them all back against an arithmetic reference. The small depth also leaves room for directed sequences of each control ending a write, lanes closing on different edges, a read on the commit edge, and every strobe pattern on reads, writes and deselected or output-disabled cycles.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_HIZ   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_dec.sv
module sram_dec
  import sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic [LANES-1:0] be_ni,
  output logic [LANES-1:0] wr_act_o,
  output logic [LANES-1:0] rd_en_o
);
  sram_mode_e mode;

  always_comb begin
    if (ce_ni)       mode = MODE_OFF;
    else if (!we_ni) mode = MODE_WRITE;
    else if (oe_ni)  mode = MODE_HIZ;
    else             mode = MODE_READ;
  end

  always_comb begin
    wr_act_o = '0;
    rd_en_o  = '0;
    unique case (mode)
      MODE_WRITE: wr_act_o = ~be_ni;
      MODE_READ:  rd_en_o  = ~be_ni;
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] din_i,
  input  logic              wr_act_i,
  input  logic              rd_en_i,
  output logic [LANE_W-1:0] dout_o,
  output logic              drv_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic              pend_act;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANE_W-1:0] pend_data;
  logic              commit;
  logic [LANE_W-1:0] rd_word;

  // window seen closed on this edge
  assign commit  = pend_act && !wr_act_i;
  assign rd_word = (commit && pend_addr == addr_i) ? pend_data : mem[addr_i];

  always_ff @(posedge clk_i) begin
    if (commit) mem[pend_addr] <= pend_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_act  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      dout_o    <= '0;
      drv_o     <= 1'b0;
    end else begin
      pend_act <= wr_act_i;
      if (wr_act_i) begin
        pend_addr <= addr_i;
        pend_data <= din_i;
      end
      dout_o <= rd_en_i ? rd_word : '0;
      drv_o  <= rd_en_i;
    end
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce_ni,
  input  logic                    we_ni,
  input  logic                    oe_ni,
  input  logic [LANES-1:0]        be_ni,
  input  logic [LANES*LANE_W-1:0] din_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic [LANES-1:0]        drv_o
);
  logic [LANES-1:0] wr_act;
  logic [LANES-1:0] rd_en;

  sram_dec #(.LANES(LANES)) u_dec (
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .oe_ni    (oe_ni),
    .be_ni    (be_ni),
    .wr_act_o (wr_act),
    .rd_en_o  (rd_en)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (addr_i),
      .din_i    (din_i[l*LANE_W +: LANE_W]),
      .wr_act_i (wr_act[l]),
      .rd_en_i  (rd_en[l]),
      .dout_o   (dout_o[l*LANE_W +: LANE_W]),
      .drv_o    (drv_o[l])
    );
  end
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int LANES  = 2,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [LANES-1:0]  be_ni,
  input logic [DATA_W-1:0] dout_o,
  input logic [LANES-1:0]  drv_o
);
  a_r2_deselect_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (drv_o == '0 && dout_o == '0));

  a_r4_oe_off_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && oe_ni) |=> (drv_o == '0));

  a_r5_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> (drv_o == '0));

  a_r3_read_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && !oe_ni) |=> (drv_o == ~$past(be_ni)));

  a_r3_drive_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_o != '0) |-> $past(!ce_ni && we_ni && !oe_ni));
endmodule

bind bytelane_sram sram_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ce_ni  (ce_ni),
  .we_ni  (we_ni),
  .oe_ni  (oe_ni),
  .be_ni  (be_ni),
  .dout_o (dout_o),
  .drv_o  (drv_o)
);

// File: tb/bytelane_sram_tb.sv
module bytelane_sram_tb;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]    be_n = 2'b11;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic [1:0]    drv;

  logic [15:0] model [N];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .be_ni(be_n), .din_i(din), .dout_o(dout), .drv_o(drv)
  );

  task automatic step(input logic c, w, o, input logic [1:0] b,
                      input logic [AW-1:0] a, input logic [15:0] d);
    ce_n = c; we_n = w; oe_n = o; be_n = b; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [17:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] b);
    return {{8{~b[1]}}, {8{~b[0]}}};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [1:0] b, input logic o);
    step(1'b0, 1'b0, o, b, a, ~d);
    step(1'b0, 1'b0, o, b, a, d);
    chk("R5", {drv, 16'h0}, 18'h0);
    step(1'b1, 1'b1, 1'b1, 2'b11, a, 16'h0);
    model[a] = (model[a] & ~lane_mask(b)) | (d & lane_mask(b));
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [1:0] b);
    step(1'b0, 1'b1, 1'b0, b, a, 16'hDEAD);
    chk(req, {drv, dout}, {~b, model[a] & lane_mask(b)});
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", {drv, dout}, 18'h0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
    chk("R1", {drv, dout}, 18'h0);

    // R9 full-depth sweep
    for (int a = 0; a < N; a++) wr(AW'(a), 16'(a * 16'h1357) ^ 16'hA5C3, 2'b00, 1'b1);
    for (int a = 0; a < N; a++) rd("R9", AW'(a), 2'b00);

    // R6 single-lane writes
    for (int a = 0; a < N; a++) wr(AW'(a), 16'(a * 16'h0F1D + 16'h3C00), 2'b10, 1'b0);
    for (int a = 0; a < N; a++) rd("R6", AW'(a), 2'b00);
    for (int a = 0; a < N; a++) wr(AW'(a), 16'(a * 16'h2B07 + 16'h0011), 2'b01, 1'b1);
    for (int a = 0; a < N; a++) rd("R6", AW'(a), 2'b00);
    wr(AW'(2), 16'hFFFF, 2'b11, 1'b0);
    rd("R6", AW'(2), 2'b00);

    // R3 strobe patterns on reads
    rd("R3", AW'(9), 2'b01);
    rd("R3", AW'(9), 2'b10);
    rd("R3", AW'(9), 2'b11);

    // R4 output disabled
    step(1'b0, 1'b1, 1'b1, 2'b00, AW'(9), '0);
    chk("R4", {drv, dout}, 18'h0);

    // R2 deselected, incl. write attempt
    step(1'b1, 1'b1, 1'b0, 2'b00, AW'(4), '0);
    chk("R2", {drv, dout}, 18'h0);
    step(1'b1, 1'b0, 1'b0, 2'b00, AW'(4), 16'h7777);
    chk("R2", {drv, dout}, 18'h0);
    step(1'b1, 1'b1, 1'b1, 2'b11, AW'(4), '0);
    rd("R2", AW'(4), 2'b00);

    // R7 lanes closing on different edges
    step(1'b0, 1'b0, 1'b1, 2'b00, AW'(3), 16'h1111);
    step(1'b0, 1'b0, 1'b1, 2'b00, AW'(3), 16'hAB22);
    step(1'b0, 1'b0, 1'b1, 2'b10, AW'(3), 16'h99CD);
    step(1'b1, 1'b1, 1'b1, 2'b11, AW'(3), 16'h0000);
    model[3] = 16'hABCD;
    rd("R7", AW'(3), 2'b00);

    // R7 chip enable ends the write
    step(1'b0, 1'b0, 1'b1, 2'b00, AW'(5), 16'h1234);
    step(1'b1, 1'b0, 1'b1, 2'b00, AW'(5), 16'hFFFF);
    step(1'b1, 1'b1, 1'b1, 2'b11, AW'(5), 16'h0000);
    model[5] = 16'h1234;
    rd("R7", AW'(5), 2'b00);

    // R8 read on the commit edge
    step(1'b0, 1'b0, 1'b1, 2'b00, AW'(7), 16'h5A5A);
    step(1'b0, 1'b0, 1'b1, 2'b00, AW'(7), 16'h5A5A);
    step(1'b0, 1'b1, 1'b0, 2'b00, AW'(7), 16'h0000);
    chk("R8", {drv, dout}, {2'b11, 16'h5A5A});
    model[7] = 16'h5A5A;
    rd("R8", AW'(7), 2'b00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule